// File: doc/BRIEF.md
# Flash Page-Program Write Sequencer

This block turns one write request (start address, byte count) into the command traffic that a serial NOR flash needs in order to store the bytes. The write data arrives as a byte stream with valid/ready handshaking. The block cuts the request into chunks so that no chunk crosses a 256-byte page. Each chunk goes through a fixed handshake on the SPI pins. First it waits until the flash reports that it is idle. Then it sets the write latch, sends a program frame with the chunk's data, and polls again until the program operation has finished.

An internal byte shifter drives the SPI pins in mode 0 (clock idle low, data sampled on the rising edge, most significant bit first). An input from an earlier probing stage selects either three or four address bytes. That input is captured when the request is accepted. Retry and read-back verification are not part of this block.

Top module: `flash_page_writer`

## Requirements
- R1: A request with a length of zero is accepted in the idle state and raises `done` on the next clock edge. Chip select never goes low for it.
- R2: The first chunk carries min(256 − (start address mod 256), length) bytes. Each later chunk starts on a page boundary and carries min(256, bytes left). Each chunk uses exactly four chip-select frames, so a request of N chunks produces 4·N frames.
- R3: The frame just before each program frame holds the single byte 0x06 and nothing else.
- R4: Before each 0x06 frame there is a status-poll frame. It sends 0x05 and then dummy bytes, and it ends right after the first returned byte whose bit 0 (busy) is 0.
- R5: When four-byte addressing is off, a program frame starts with opcode 0x02 and then address bits [23:16], [15:8] and [7:0].
- R6: When four-byte addressing is on, a program frame starts with opcode 0x12 and then address bits [31:24], [23:16], [15:8] and [7:0].
- R7: The chunk's data bytes follow the address in the same frame, in the order they were accepted on the stream. The stream accepts exactly `length` bytes per request.
- R8: Each program frame is followed by another status-poll frame of the form given in R4. `done` is raised only after the last one sees bit 0 clear.
- R9: `in_ready` is high only while chip select is low, `spi_sck` is low and the shifter is waiting for the next data byte of a program frame.
- R10: `spi_sck` is low whenever chip select is high. `spi_mosi` does not change while `spi_sck` is high. Chip select is high whenever the block is idle.
- R11: `done` lasts exactly one cycle and appears with `busy` low. `busy` is high from the cycle after a non-empty request is accepted until that `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe; only accepted while `busy` is low |
| start_addr | input | 32 | First flash byte address of the write |
| start_len | input | LEN_W | Number of bytes to write |
| addr4 | input | 1 | 1 selects four address bytes and opcode 0x12 |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| in_valid | input | 1 | Write data byte is valid |
| in_data | input | 8 | Write data byte |
| in_ready | output | 1 | Block takes `in_data` at this edge if `in_valid` |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to flash |
| spi_miso | input | 1 | SPI data from flash |

## Verification
The assertions check the pin-level rules on every cycle. These are: chip select high when idle, clock low outside a frame, MOSI stable while the clock is high, `in_ready` only inside a frame with the clock low, and the one-cycle `done` pulse that arrives while idle. Several behaviours can only be shown by the bench's flash model over whole requests. These include the page-boundary split, the order of poll, enable, program and poll frames, the opcodes and address byte order of both address modes, and data order under a stalling stream. The same holds for polling, which must keep going while the model reports busy and must stop at the first clear status.

// File: rtl/flash_page_writer.sv
module flash_page_writer #(
  parameter int LEN_W     = 16,
  parameter int PAGE_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      start_addr,
  input  logic [LEN_W-1:0] start_len,
  input  logic             addr4,
  output logic             busy,
  output logic             done,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             spi_sck,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int PAGE = 1 << PAGE_BITS;

  typedef enum logic [1:0] {IDLE, POLL, WREN, PROG} st_t;
  st_t st;

  logic [31:0]        addr;
  logic [LEN_W-1:0]   rem;
  logic [PAGE_BITS:0] clen;
  logic               a4, post, cs_n, done_r;
  logic [2:0]         idx;

  logic [7:0] tx, rx;
  logic [2:0] bitn;
  logic       shifting, sck;
  logic       ld;
  logic [7:0] ldb;

  wire       byte_done = shifting & sck & (bitn == 3'd7);
  wire [2:0] na        = a4 ? 3'd4 : 3'd3;
  wire       data_ph   = (st == PROG) & ~cs_n & ~shifting & (idx == na + 3'd1);
  wire [2:0] bsel      = na - idx;
  wire [31:0] ash      = addr >> {bsel[1:0], 3'b000};

  wire [PAGE_BITS:0] room  = (PAGE_BITS+1)'(PAGE) - {1'b0, addr[PAGE_BITS-1:0]};
  wire [PAGE_BITS:0] first = (rem < LEN_W'(room)) ? rem[PAGE_BITS:0] : room;

  assign in_ready = data_ph & (clen != '0);
  assign busy     = (st != IDLE);
  assign done     = done_r;
  assign spi_sck  = sck;
  assign spi_cs_n = cs_n;
  assign spi_mosi = tx[7];

  always_comb begin
    ld  = 1'b0;
    ldb = 8'h00;
    case (st)
      POLL: if (cs_n) begin ld = 1'b1; ldb = 8'h05; end
            else if (byte_done && (idx == 3'd0 || rx[0])) ld = 1'b1;
      WREN: if (cs_n) begin ld = 1'b1; ldb = 8'h06; end
      PROG: if (cs_n) begin ld = 1'b1; ldb = a4 ? 8'h12 : 8'h02; end
            else if (byte_done && idx <= na) begin ld = 1'b1; ldb = ash[7:0]; end
            else if (in_valid && in_ready) begin ld = 1'b1; ldb = in_data; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck <= 1'b0; tx <= '0; rx <= '0; bitn <= '0; shifting <= 1'b0;
    end else if (ld) begin
      sck <= 1'b0; tx <= ldb; bitn <= '0; shifting <= 1'b1;
    end else if (shifting) begin
      if (!sck) begin
        sck <= 1'b1;
        rx  <= {rx[6:0], spi_miso};
      end else begin
        sck  <= 1'b0;
        tx   <= {tx[6:0], 1'b0};
        bitn <= bitn + 3'd1;
        if (bitn == 3'd7) shifting <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; addr <= '0; rem <= '0; clen <= '0; a4 <= 1'b0;
      post <= 1'b0; cs_n <= 1'b1; done_r <= 1'b0; idx <= '0;
    end else begin
      done_r <= 1'b0;
      case (st)
        IDLE: if (start) begin
          if (start_len == '0) done_r <= 1'b1;
          else begin
            st <= POLL; post <= 1'b0;
            addr <= start_addr; rem <= start_len; a4 <= addr4;
          end
        end
        POLL: if (cs_n) begin
          cs_n <= 1'b0; idx <= 3'd0;
        end else if (byte_done) begin
          if (idx == 3'd0) idx <= 3'd1;
          else if (!rx[0]) begin
            cs_n <= 1'b1;
            if (!post) st <= WREN;
            else if (rem == '0) begin st <= IDLE; done_r <= 1'b1; end
            else post <= 1'b0;
          end
        end
        WREN: if (cs_n) cs_n <= 1'b0;
              else if (byte_done) begin cs_n <= 1'b1; st <= PROG; end
        PROG: if (cs_n) begin
          cs_n <= 1'b0; idx <= 3'd1; clen <= first;
        end else if (byte_done && idx <= na) begin
          idx <= idx + 3'd1;
        end else if (in_valid && in_ready) begin
          clen <= clen - 1'b1; addr <= addr + 32'd1; rem <= rem - 1'b1;
        end else if (data_ph && clen == '0) begin
          cs_n <= 1'b1; st <= POLL; post <= 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_page_writer_chk.sv
module flash_page_writer_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [31:0]      start_addr,
  input logic [LEN_W-1:0] start_len,
  input logic             addr4,
  input logic             busy,
  input logic             done,
  input logic             in_valid,
  input logic [7:0]       in_data,
  input logic             in_ready,
  input logic             spi_sck,
  input logic             spi_cs_n,
  input logic             spi_mosi,
  input logic             spi_miso
);
  assert_idle_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n);
  assert_sck_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  assert_mosi_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> $stable(spi_mosi));
  assert_ready_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!spi_cs_n && !spi_sck && busy));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind flash_page_writer flash_page_writer_chk #(.LEN_W(LEN_W)) i_chk (.*);

// File: tb/test_flash_page_writer.sv
module test_flash_page_writer;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, addr4 = 1'b0, in_valid = 1'b0, spi_miso = 1'b0;
  logic [31:0] start_addr = '0;
  logic [LEN_W-1:0] start_len = '0;
  logic [7:0] in_data = '0;
  logic busy, done, in_ready, spi_sck, spi_cs_n, spi_mosi;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_page_writer #(.LEN_W(LEN_W)) i_flash_page_writer (.*);

  int n_chk = 0, n_fail = 0, cycles = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // flash model
  logic [7:0] log_b [0:2047];
  int fr_st [0:63];
  int fr_n = 0, log_n = 0, bitc = 0, busy_left = 0, model_err = 0;
  logic [7:0] in_sr = '0, out_sr = '0;
  bit pend_stat = 0, zero_seen = 0;

  function automatic int cur_len();
    return log_n - fr_st[fr_n-1];
  endfunction

  always @(negedge spi_cs_n) begin
    if (rst_n && fr_n < 64) begin
      fr_st[fr_n] = log_n; fr_n++;
      bitc = 0; zero_seen = 0;
    end
  end

  always @(posedge spi_cs_n) begin
    if (fr_n > 0 && cur_len() > 0) begin
      if (log_b[fr_st[fr_n-1]] == 8'h02 || log_b[fr_st[fr_n-1]] == 8'h12)
        busy_left = $urandom_range(0, 3);
      if (log_b[fr_st[fr_n-1]] == 8'h05 && !zero_seen) model_err++;
    end
  end

  always @(posedge spi_sck) begin
    in_sr = {in_sr[6:0], spi_mosi};
    bitc++;
    if (bitc == 8 && fr_n > 0) begin
      bitc = 0;
      if (log_n < 2048) log_b[log_n] = in_sr;
      log_n++;
      if (log_b[fr_st[fr_n-1]] == 8'h05) begin
        if (cur_len() >= 2) begin
          if (zero_seen) model_err++;
          if (!pend_stat) zero_seen = 1;
        end
        pend_stat = (busy_left > 0);
        if (busy_left > 0) busy_left--;
        out_sr = {7'd0, pend_stat};
      end else out_sr = 8'hA5;
    end
  end

  always @(negedge spi_sck) begin
    spi_miso = out_sr[7];
    out_sr = {out_sr[6:0], 1'b0};
  end

  // data stream
  int sidx = 0, ready_err = 0;
  bit hs = 0, stream_en = 0;
  logic [7:0] base = 8'd0;

  function automatic logic [7:0] dat(input int k);
    return base + 8'(k * 29);
  endfunction

  always @(negedge clk) begin
    if (hs) sidx++;
    in_valid = stream_en && ($urandom_range(0, 3) != 0);
    in_data  = dat(sidx);
    hs = in_valid && in_ready;
    if (in_ready && spi_cs_n) ready_err++;
  end

  function automatic int flen(input int f);
    return ((f + 1 < fr_n) ? fr_st[f+1] : log_n) - fr_st[f];
  endfunction

  task automatic run_req(input logic [31:0] a0, input int len, input bit four);
    int f, r, c, k, na, wt, bad;
    logic [31:0] a;
    @(negedge clk);
    fr_n = 0; log_n = 0; model_err = 0; ready_err = 0; sidx = 0;
    busy_left = $urandom_range(0, 3); base = 8'($urandom);
    stream_en = 1;
    start = 1; start_addr = a0; start_len = LEN_W'(len); addr4 = four;
    @(negedge clk);
    start = 0;
    if (len == 0) begin
      chk(done == 1'b1, "R1 done after empty request", done, 1);
      repeat (20) @(negedge clk);
      chk(fr_n == 0, "R1 no frames for empty request", fr_n, 0);
      chk(busy == 1'b0, "R1 idle after empty request", busy, 0);
      stream_en = 0;
      return;
    end
    chk(busy == 1'b1, "R11 busy after accept", busy, 1);
    wt = 0;
    while (!done && wt < 60000) begin
      @(negedge clk); wt++;
      if (!done && !busy) break;
    end
    chk(done == 1'b1, "R11 done reached", done, 1);
    chk(busy == 1'b0, "R11 busy low with done", busy, 0);
    chk(busy_left == 0, "R8 flash idle at done", busy_left, 0);
    @(negedge clk);
    chk(done == 1'b0, "R11 done one cycle", done, 0);
    stream_en = 0;
    repeat (3) @(negedge clk);

    na = four ? 4 : 3;
    f = 0; r = len; k = 0; a = a0;
    while (r > 0) begin
      c = 256 - int'(a[7:0]);
      if (c > r) c = r;
      if (f + 3 >= fr_n) begin
        chk(0, "R2 frames present", fr_n, f + 4);
        break;
      end
      chk(log_b[fr_st[f]] == 8'h05 && flen(f) >= 2, "R4 pre-poll frame",
          log_b[fr_st[f]], 8'h05);
      chk(flen(f+1) == 1 && log_b[fr_st[f+1]] == 8'h06, "R3 write-enable frame",
          flen(f+1), 1);
      chk(flen(f+2) == 1 + na + c, "R2 chunk length", flen(f+2) - 1 - na, c);
      if (four) begin
        chk(log_b[fr_st[f+2]] == 8'h12, "R6 opcode", log_b[fr_st[f+2]], 8'h12);
        chk({log_b[fr_st[f+2]+1], log_b[fr_st[f+2]+2], log_b[fr_st[f+2]+3],
             log_b[fr_st[f+2]+4]} == a, "R6 address bytes",
            {log_b[fr_st[f+2]+1], log_b[fr_st[f+2]+2], log_b[fr_st[f+2]+3],
             log_b[fr_st[f+2]+4]}, a);
      end else begin
        chk(log_b[fr_st[f+2]] == 8'h02, "R5 opcode", log_b[fr_st[f+2]], 8'h02);
        chk({log_b[fr_st[f+2]+1], log_b[fr_st[f+2]+2], log_b[fr_st[f+2]+3]}
            == a[23:0], "R5 address bytes",
            {log_b[fr_st[f+2]+1], log_b[fr_st[f+2]+2], log_b[fr_st[f+2]+3]},
            a[23:0]);
      end
      bad = 0;
      for (int i = 0; i < c; i++)
        if (log_b[fr_st[f+2] + 1 + na + i] != dat(k + i)) bad++;
      chk(bad == 0, "R7 data bytes in order", bad, 0);
      chk(log_b[fr_st[f+3]] == 8'h05 && flen(f+3) >= 2, "R8 post-poll frame",
          log_b[fr_st[f+3]], 8'h05);
      a = a + 32'(c); r -= c; k += c; f += 4;
    end
    chk(fr_n == f, "R2 total frame count", fr_n, f);
    chk(model_err == 0, "R4 poll stops at first clear status", model_err, 0);
    chk(sidx == len, "R7 bytes accepted", sidx, len);
    chk(ready_err == 0, "R9 ready outside frame", ready_err, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R10 reset pins", {spi_cs_n, spi_sck}, 2);
    chk(busy == 0 && done == 0 && in_ready == 0, "R11 reset outputs",
        {busy, done, in_ready}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_req(32'h0000_0010, 20, 0);
    run_req(32'h0000_00F0, 40, 0);
    run_req(32'h0001_2300, 256, 0);
    run_req(32'h1234_56F0, 300, 1);
    run_req(32'h0000_0000, 0, 0);
    run_req(32'h0000_00FF, 1, 0);
    run_req(32'h00AB_CD00, 0, 1);
    for (int n = 0; n < 6; n++)
      run_req($urandom, $urandom_range(1, 300), 1'($urandom_range(0, 1)));
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule